// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Control

This block is the hazard logic for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It compares register specifiers held in the pipeline registers. It produces two kinds of output. The first is a multiplexer select for each of the two execute-stage ALU operands, so that a result still travelling down the pipeline reaches a dependent instruction without waiting. The second is a set of stall controls that opens a one-cycle gap when forwarding cannot help.

Forwarding cannot help when a load in execute produces data that the instruction in decode needs. In that case the block holds the program counter and the fetch/decode register, and it clears the control bits that enter the decode/execute register, which turns them into a no-op. All other read-after-write dependencies are resolved by forwarding and do not stall. Register 31 is hardwired to zero, so it never takes part in either mechanism. The block holds no state: every output is a function of the current inputs.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When the memory-stage destination equals an execute-stage source, is not register 31, and its write enable is high, that operand's select is 2'b10 (take the memory-stage result).
- R2: When only the writeback-stage destination matches an execute-stage source under the same conditions, that operand's select is 2'b01 (take the writeback result).
- R3: When both the memory stage and the writeback stage match the same source, the select is 2'b10, because the younger result wins.
- R4: A stage whose write enable is low never supplies a forwarded value. If no other stage qualifies, the select is 2'b00 (register file).
- R5: A source of register 31 always selects 2'b00, even when a producing stage writes register 31.
- R6: The selects for operand A and operand B are computed independently, each from its own execute-stage source. The value 2'b11 never appears.
- R7: When the execute-stage instruction reads memory and its destination equals either decode-stage source, the PC write enable and the fetch/decode write enable are 0, and the decode/execute control-clear output is 1.
- R8: An execute-stage producer that does not read memory never causes a stall, even when its destination matches.
- R9: A load whose destination is register 31 never causes a stall.
- R10: When there is no load-use match, both write enables are 1 and the control-clear output is 0.
- R11: All outputs settle within the same cycle in which the inputs are applied. Stall and forwarding decisions may be active at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | 5 | First source register of the instruction in decode |
| id_rs2_i | input | 5 | Second source register of the instruction in decode |
| ex_rs1_i | input | 5 | First source register of the instruction in execute |
| ex_rs2_i | input | 5 | Second source register of the instruction in execute |
| ex_rd_i | input | 5 | Destination register of the instruction in execute |
| ex_mem_read_i | input | 1 | The instruction in execute is a load |
| mem_rd_i | input | 5 | Destination register held in the execute/memory register |
| mem_we_i | input | 1 | Register-write enable held in the execute/memory register |
| wb_rd_i | input | 5 | Destination register held in the memory/writeback register |
| wb_we_i | input | 1 | Register-write enable held in the memory/writeback register |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback |
| fwd_b_o | output | 2 | Operand B select, with the same encoding |
| pc_we_o | output | 1 | PC write enable; 0 holds the PC |
| ifid_we_o | output | 1 | Fetch/decode register write enable; 0 holds it |
| idex_clear_o | output | 1 | 1 zeroes the control bits entering decode/execute |

## Verification
Every result of this block is combinational, so each select and stall output is due in the same cycle in which its register specifiers are applied. No result is delayed by a whole cycle. The driver applies one stimulus just after a rising edge and queues the outputs expected for it. The monitor removes that entry at the following falling edge and compares it there, while the inputs are still stable. Each stimulus is held for exactly one cycle, so every queue entry matches the input set that was present when it was sampled.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_WB    = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/operand_fwd_sel.sv
module operand_fwd_sel
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);

  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  logic hit_mem;
  logic hit_wb;

  always_comb begin
    hit_mem = mem_we_i && (mem_rd_i != ZR) && (mem_rd_i == src_i);
    hit_wb  = wb_we_i  && (wb_rd_i  != ZR) && (wb_rd_i  == src_i);
    if (hit_mem)     sel_o = FWD_EXMEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31,
  parameter int unsigned NUM_SRC  = 2
) (
  input  logic                          ex_mem_read_i,
  input  logic [REG_W-1:0]              ex_rd_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  output logic                          stall_o
);

  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = (id_src_i[g] == ex_rd_i);
  end

  always_comb begin
    stall_o = ex_mem_read_i && (ex_rd_i != ZR) && (|src_hit);
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_mem_read_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             idex_clear_o
);

  localparam int unsigned NUM_OPND = 2;

  logic [NUM_OPND-1:0][REG_W-1:0] ex_src;
  logic [NUM_OPND-1:0][REG_W-1:0] id_src;
  fwd_sel_e                       sel [NUM_OPND];
  logic                           stall;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    operand_fwd_sel #(
      .REG_W    (REG_W),
      .ZERO_REG (ZERO_REG)
    ) u_sel (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  load_use_detect #(
    .REG_W    (REG_W),
    .ZERO_REG (ZERO_REG),
    .NUM_SRC  (NUM_OPND)
  ) u_lud (
    .ex_mem_read_i (ex_mem_read_i),
    .ex_rd_i       (ex_rd_i),
    .id_src_i      (id_src),
    .stall_o       (stall)
  );

  always_comb begin
    fwd_a_o      = sel[0];
    fwd_b_o      = sel[1];
    pc_we_o      = !stall;
    ifid_we_o    = !stall;
    idex_clear_o = stall;
  end

endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input logic [REG_W-1:0] ex_rs1_i,
  input logic [REG_W-1:0] ex_rs2_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_mem_read_i,
  input logic             mem_we_i,
  input logic             wb_we_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             pc_we_o,
  input logic             ifid_we_o,
  input logic             idex_clear_o
);

  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  always_comb begin
    assert_stall_coherent_R7: assert ((pc_we_o == ifid_we_o) && (idex_clear_o == !pc_we_o))
      else $error("stall controls disagree");
    assert_zero_src_no_fwd_R5: assert (((ex_rs1_i != ZR) || (fwd_a_o == 2'b00)) &&
                                       ((ex_rs2_i != ZR) || (fwd_b_o == 2'b00)))
      else $error("register 31 forwarded");
    assert_no_we_no_fwd_R4: assert (mem_we_i || wb_we_i || ((fwd_a_o == 2'b00) && (fwd_b_o == 2'b00)))
      else $error("forward without write enable");
    assert_sel_legal_R6: assert ((fwd_a_o != 2'b11) && (fwd_b_o != 2'b11))
      else $error("illegal select code");
    assert_no_load_no_stall_R8: assert (ex_mem_read_i || pc_we_o)
      else $error("stall without load");
    assert_zero_load_no_stall_R9: assert ((ex_rd_i != ZR) || pc_we_o)
      else $error("stall on register 31 load");
  end

endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(
  .REG_W    (REG_W),
  .ZERO_REG (ZERO_REG)
) u_chk (
  .ex_rs1_i      (ex_rs1_i),
  .ex_rs2_i      (ex_rs2_i),
  .ex_rd_i       (ex_rd_i),
  .ex_mem_read_i (ex_mem_read_i),
  .mem_we_i      (mem_we_i),
  .wb_we_i       (wb_we_i),
  .fwd_a_o       (fwd_a_o),
  .fwd_b_o       (fwd_b_o),
  .pc_we_o       (pc_we_o),
  .ifid_we_o     (ifid_we_o),
  .idex_clear_o  (idex_clear_o)
);

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;

  logic clk;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_mem_read, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, idex_clear;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [1:0] exp_a_q[$];
  logic [1:0] exp_b_q[$];
  logic       exp_st_q[$];
  string      tag_q[$];

  pipe_hazard_unit uut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .ex_rd_i(ex_rd), .ex_mem_read_i(ex_mem_read), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_clear_o(idex_clear)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic apply(input logic [4:0] i1, input logic [4:0] i2,
                       input logic [4:0] e1, input logic [4:0] e2,
                       input logic [4:0] erd, input logic ld,
                       input logic [4:0] mrd, input logic mwe,
                       input logic [4:0] wrd, input logic wwe,
                       input logic [1:0] xa, input logic [1:0] xb,
                       input logic xst, input string tag);
    @(posedge clk);
    #1;
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
    ex_mem_read = ld; mem_rd = mrd; mem_we = mwe; wb_rd = wrd; wb_we = wwe;
    exp_a_q.push_back(xa);
    exp_b_q.push_back(xb);
    exp_st_q.push_back(xst);
    tag_q.push_back(tag);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (tag_q.size() > 0) begin
        logic [1:0] xa, xb;
        logic xst;
        string t;
        xa = exp_a_q.pop_front();
        xb = exp_b_q.pop_front();
        xst = exp_st_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "fwd_a", int'(fwd_a), int'(xa));
        cmp(t, "fwd_b", int'(fwd_b), int'(xb));
        cmp(t, "pc_we", int'(pc_we), int'(!xst));
        cmp(t, "ifid_we", int'(ifid_we), int'(!xst));
        cmp(t, "idex_clear", int'(idex_clear), int'(xst));
      end
    end
  end

  initial begin
    id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
    ex_mem_read = 1'b0; mem_rd = '0; mem_we = 1'b0; wb_rd = '0; wb_we = 1'b0;
    // idle state: nothing forwarded, no stall (R10)
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R10");
    // memory-stage forward to operand A only (R1)
    apply(1, 2, 5, 6, 0, 0, 5, 1, 0, 0, 2'b10, 2'b00, 0, "R1");
    // writeback forward to operand B (R2)
    apply(1, 2, 3, 7, 0, 0, 0, 0, 7, 1, 2'b00, 2'b01, 0, "R2");
    // both stages match: younger wins on both operands (R3)
    apply(1, 2, 9, 9, 0, 0, 9, 1, 9, 1, 2'b10, 2'b10, 0, "R3");
    // memory stage matches but not writing: falls through to writeback (R4)
    apply(1, 2, 4, 0, 0, 0, 4, 0, 4, 1, 2'b01, 2'b00, 0, "R4");
    // neither writing: register file (R4)
    apply(1, 2, 4, 4, 0, 0, 4, 0, 4, 0, 2'b00, 2'b00, 0, "R4");
    // register 31 never forwarded (R5)
    apply(1, 2, 31, 31, 0, 0, 31, 1, 31, 1, 2'b00, 2'b00, 0, "R5");
    // independent operands: A from memory stage, B from writeback (R6)
    apply(1, 2, 3, 6, 0, 0, 3, 1, 6, 1, 2'b10, 2'b01, 0, "R6");
    // load-use on first decode source (R7)
    apply(8, 2, 0, 0, 8, 1, 0, 0, 0, 0, 2'b00, 2'b00, 1, "R7");
    // load-use on second decode source (R7)
    apply(1, 8, 0, 0, 8, 1, 0, 0, 0, 0, 2'b00, 2'b00, 1, "R7");
    // matching producer that is not a load: no stall (R8)
    apply(8, 8, 0, 0, 8, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R8");
    // load into register 31: no stall (R9)
    apply(31, 31, 0, 0, 31, 1, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R9");
    // load with no matching consumer: no stall (R10)
    apply(1, 2, 0, 0, 8, 1, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R10");
    // stall and forwarding at once, same cycle (R11)
    apply(12, 2, 5, 6, 12, 1, 5, 1, 6, 1, 2'b10, 2'b01, 1, "R11");
    // back to idle the very next cycle (R11)
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R11");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule